// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block decides when an SDRAM controller must spend a slot on an auto-refresh. An interval timer adds one owed refresh each time it expires. The number of owed refreshes is held in a small saturating backlog counter. While the backlog is non-zero and no refresh is recovering, the scheduler raises its request. The controller answers with a grant in a cycle in which every bank is precharged. The scheduler takes that grant as the moment the auto-refresh command goes out. It then holds its busy output for the row-cycle time, and the controller must issue nothing during that window.

The controller may let the backlog grow during long bursts. An urgency output tells it when the backlog is close to the limit, so that it closes its banks and grants. With the defaults, one interval is 1562 clocks at 100 MHz, which spreads 4096 refreshes over each 64 ms. Recovery lasts 7 clocks (70 ns). At most 8 refreshes can be owed, and urgency starts at 6.

Top module: `sdram_refresh_sched`

## Requirements
- R1: In reset and in the first cycle after it, refresh_req_o, busy_o and urgent_o are all low and nothing is owed.
- R2: The first owed refresh appears exactly TICK_PERIOD clocks after reset is released. Refresh_req_o rises in the cycle after the timer's last count. Each further TICK_PERIOD clocks adds one more owed refresh.
- R3: A refresh is accepted only in a cycle where grant_i, banks_idle_i and refresh_req_o are all high. A grant in any other cycle changes neither busy_o nor the owed count.
- R4: After an accepted grant, busy_o is high for exactly RECOVERY_CLKS cycles, starting with the next cycle. refresh_req_o is low while busy_o is high.
- R5: Each accepted grant lowers the owed count by one. refresh_req_o falls only when the count reaches zero.
- R6: If an accepted grant falls in the same cycle as the timer's last count, the owed count stays unchanged.
- R7: The owed count saturates at MAX_OWED. Timer expiries with a full backlog are dropped.
- R8: urgent_o is high exactly when the owed count is at least URGENT_LEVEL.
- R9: A grant while busy_o is high neither restarts nor lengthens the recovery window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| grant_i | input | 1 | Controller offers the current cycle for a refresh |
| banks_idle_i | input | 1 | All banks are in the precharged state |
| refresh_req_o | output | 1 | At least one refresh owed and no recovery running |
| busy_o | output | 1 | Recovery window after an accepted refresh; controller must hold off |
| urgent_o | output | 1 | Backlog has reached the urgency level |

## Verification
A wrong backlog count shows at the ports within one interval. It shows as a request that drops too early or stays up too long after the last grant, or as urgency at the wrong level. A timer that is off by one count moves the rise of the request by a cycle, and a cycle-exact comparison catches this at the first expiry after reset. A recovery counter that loads or decays wrongly changes the length of busy_o at once, on the first accepted grant. Grants timed on an expiry cycle and grants given while busy target the two same-cycle conflicts that a plain counter mix-up would break.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;
  // Default timing for a 100 MHz clock: 64 ms / 4096 rows = 15.625 us
  localparam int unsigned DEF_TICK_PERIOD   = 1562;
  localparam int unsigned DEF_RECOVERY_CLKS = 7;
  localparam int unsigned DEF_MAX_OWED      = 8;
  localparam int unsigned DEF_URGENT_LEVEL  = 6;

  // Backlog update selected by the two events of a cycle
  typedef enum logic [1:0] {
    BK_HOLD = 2'b00,
    BK_ADD  = 2'b01,
    BK_TAKE = 2'b10,
    BK_BOTH = 2'b11
  } backlog_op_e;
endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
  parameter int unsigned TICK_PERIOD = 1562
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned CW   = (TICK_PERIOD > 1) ? $clog2(TICK_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_RELOAD: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> (cnt_q == '0)); // R2

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R2
endmodule

// File: rtl/rfs_backlog.sv
module rfs_backlog
  import sdram_refresh_pkg::*;
#(
  parameter int unsigned MAX_OWED     = 8,
  parameter int unsigned URGENT_LEVEL = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic add_i,
  input  logic take_i,
  output logic pending_o,
  output logic urgent_o
);
  localparam int unsigned OW = $clog2(MAX_OWED + 1);
  localparam logic [OW-1:0] FULL = OW'(MAX_OWED);
  localparam logic [OW-1:0] URG  = OW'(URGENT_LEVEL);

  logic [OW-1:0] owed_q, owed_d;
  backlog_op_e   op;

  assign op = backlog_op_e'({take_i, add_i});

  always_comb begin
    owed_d = owed_q;
    unique case (op)
      BK_ADD:  if (owed_q != FULL) owed_d = owed_q + 1'b1;
      BK_TAKE: if (owed_q != '0)   owed_d = owed_q - 1'b1;
      default: owed_d = owed_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owed_q    <= '0;
      pending_o <= 1'b0;
      urgent_o  <= 1'b0;
    end else begin
      owed_q    <= owed_d;
      pending_o <= (owed_d != '0);
      urgent_o  <= (owed_d >= URG);
    end
  end

  AST_OWED_LIMIT: assert property (@(posedge clk) disable iff (rst)
    owed_q <= FULL); // R7

  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (add_i && take_i) |=> $stable(owed_q)); // R6

  AST_URGENT_LEVEL: assert property (@(posedge clk) disable iff (rst)
    urgent_o |-> (owed_q >= URG)); // R8

  AST_TAKE_NEEDS_OWED: assert property (@(posedge clk) disable iff (rst)
    take_i |-> pending_o); // R5
endmodule

// File: rtl/rfs_recovery_timer.sv
module rfs_recovery_timer #(
  parameter int unsigned RECOVERY_CLKS = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned BW = $clog2(RECOVERY_CLKS + 1);
  localparam logic [BW-1:0] LOAD = BW'(RECOVERY_CLKS);

  logic [BW-1:0] left_q, left_d;

  always_comb begin
    if (start_i)            left_d = LOAD;
    else if (left_q != '0)  left_d = left_q - 1'b1;
    else                    left_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      busy_o <= 1'b0;
    end else begin
      left_q <= left_d;
      busy_o <= (left_d != '0);
    end
  end

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !start_i); // R9

  AST_BUSY_DECAY: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !start_i && left_q > 1) |=> busy_o); // R4
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import sdram_refresh_pkg::*;
#(
  parameter int unsigned TICK_PERIOD   = DEF_TICK_PERIOD,
  parameter int unsigned RECOVERY_CLKS = DEF_RECOVERY_CLKS,
  parameter int unsigned MAX_OWED      = DEF_MAX_OWED,
  parameter int unsigned URGENT_LEVEL  = DEF_URGENT_LEVEL
) (
  input  logic clk,
  input  logic rst,
  input  logic grant_i,
  input  logic banks_idle_i,
  output logic refresh_req_o,
  output logic busy_o,
  output logic urgent_o
);
  logic tick;
  logic pending;
  logic accept;

  rfs_interval_timer #(.TICK_PERIOD(TICK_PERIOD)) i_timer (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  rfs_backlog #(.MAX_OWED(MAX_OWED), .URGENT_LEVEL(URGENT_LEVEL)) i_backlog (
    .clk       (clk),
    .rst       (rst),
    .add_i     (tick),
    .take_i    (accept),
    .pending_o (pending),
    .urgent_o  (urgent_o)
  );

  rfs_recovery_timer #(.RECOVERY_CLKS(RECOVERY_CLKS)) i_recovery (
    .clk     (clk),
    .rst     (rst),
    .start_i (accept),
    .busy_o  (busy_o)
  );

  assign refresh_req_o = pending & ~busy_o;
  assign accept        = grant_i & banks_idle_i & refresh_req_o;

  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !refresh_req_o); // R4

  AST_START_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(grant_i && banks_idle_i)); // R3

  AST_URGENT_HAS_WORK: assert property (@(posedge clk) disable iff (rst)
    urgent_o |-> (pending || busy_o)); // R8
endmodule

// File: tb/test_sdram_refresh_sched.sv
`timescale 1ns/1ps
module test_sdram_refresh_sched;
  localparam int TP  = 20;
  localparam int RC  = 7;
  localparam int MX  = 8;
  localparam int UL  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic grant = 1'b0;
  logic idle  = 1'b0;
  logic req, busy, urg;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // bench model state
  int m_cnt = 0, m_owed = 0, m_busy = 0;
  int hit_both = 0;

  always #2 clk = ~clk;

  sdram_refresh_sched #(
    .TICK_PERIOD(TP), .RECOVERY_CLKS(RC), .MAX_OWED(MX), .URGENT_LEVEL(UL)
  ) i_sdram_refresh_sched (
    .clk(clk), .rst(rst), .grant_i(grant), .banks_idle_i(idle),
    .refresh_req_o(req), .busy_o(busy), .urgent_o(urg)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // one clock: drive at negedge, advance model, compare at next negedge
  task automatic step(input logic g, input logic i);
    bit acc, tk;
    int owed_before;
    grant = g;
    idle  = i;
    acc = g && i && (m_owed != 0) && (m_busy == 0);
    tk  = (m_cnt == TP - 1);
    owed_before = m_owed;
    if (tk && !acc && m_owed < MX) m_owed++;
    else if (acc && !tk) m_owed--;
    if (acc) m_busy = RC; else if (m_busy > 0) m_busy--;
    m_cnt = tk ? 0 : m_cnt + 1;
    @(posedge clk);
    @(negedge clk);
    cycles++;
    if (acc && tk) begin
      hit_both++;
      chk("R6 owed held on expiry+grant", urg, (owed_before >= UL));
    end else if (tk && owed_before == MX)
      chk("R7 saturation", urg, 1'b1);
    chk("R8 urgent", urg, (m_owed >= UL));
    if (g && !acc)
      chk("R3/R9 ignored grant busy", busy, (m_busy != 0));
    else
      chk("R4 busy window", busy, (m_busy != 0));
    if (acc)
      chk("R5 req after accept", req, (m_owed != 0) && (m_busy == 0));
    else
      chk("R2 req", req, (m_owed != 0) && (m_busy == 0));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 req in reset", req, 1'b0);
    chk("R1 busy in reset", busy, 1'b0);
    chk("R1 urgent in reset", urg, 1'b0);
    rst = 1'b0;
    // R1: first cycle after reset, then R2 first expiry timing
    step(1'b1, 1'b1);
    chk("R1 req after reset", req, 1'b0);
    for (int k = 1; k < TP - 1; k++) step(1'b0, 1'b0);
    chk("R2 no req before expiry", req, 1'b0);
    step(1'b0, 1'b0);
    chk("R2 req at expiry", req, 1'b1);
    // R7/R8: let the backlog fill and overflow
    for (int k = 0; k < TP * (MX + 3); k++) step(1'b0, 1'b0);
    // R3: grants with banks open
    for (int k = 0; k < 3 * TP; k++) step(1'b1, 1'b0);
    // R3: banks idle but no grant
    for (int k = 0; k < TP; k++) step(1'b0, 1'b1);
    // R4/R5/R9: grant every cycle until drained
    for (int k = 0; k < 8 * TP; k++) step(1'b1, 1'b1);
    // R6: build backlog, then grant only on expiry cycles
    for (int k = 0; k < 3 * TP; k++) step(1'b0, 1'b0);
    for (int k = 0; k < 12 * TP; k++)
      step((m_cnt == TP - 1), 1'b1);
    chk("R6 expiry+grant exercised", (hit_both > 0), 1'b1);
    // mixed traffic
    for (int k = 0; k < 4000; k++)
      step(($urandom % 5) == 0, ($urandom % 3) != 0);
    finish_run();
  end
endmodule